// File: doc/BRIEF.md
# Stack Transfer Sequencer

This block performs the byte-by-byte memory sequences that move 16-bit values between a register pair and a stack that grows toward lower addresses in byte-wide memory. It owns the stack pointer. A controller gives it an operation code and a 16-bit operand with a one-cycle start strobe. The block then issues one byte access per memory handshake. When the sequence is complete it raises a one-cycle done pulse, presents the value that was read, and shows the new stack pointer.

Six operations are supported. Push and call store a pair or a return address. Pop and return fetch a pair or a return address. Exchange swaps the operand, which holds HL, with the two bytes on top of the stack. Load-SP copies the operand into the stack pointer. For the accumulator pair, the operand carries the accumulator in its upper byte and the flags byte in its lower byte, so the same byte order applies. Decoding instructions, storing the register file and steering the program counter belong to the surrounding core.

Top module: `stk_xfer_seq`

## Requirements
- R1: Push (code 0) and call (code 2) write the operand's upper byte at SP-1 first, then its lower byte at SP-2, and leave SP at SP-2 when done.
- R2: Pop (code 1) and return (code 3) read the lower result byte at SP first, then the upper result byte at SP+1, and leave SP at SP+2 when done.
- R3: When the accumulator pair is pushed, the accumulator (operand bits 15:8) lands at the higher address and the flags byte (bits 7:0) at the lower address. A pop returns both to the same positions.
- R4: Exchange (code 4) performs a read at SP, a read at SP+1, then writes operand bits 7:0 at SP and operand bits 15:8 at SP+1, in that order. It returns the old {byte at SP+1, byte at SP} and leaves SP unchanged.
- R5: Load-SP (code 5) sets SP to the operand with no memory access, and done rises in the cycle after the start strobe is accepted.
- R6: A memory request holds its address, direction and write data steady until the cycle in which ready is high. Exactly one byte moves per accepted request.
- R7: Read data is taken from the memory bus in the cycle after the read request is accepted.
- R8: Done is a single-cycle pulse with no memory request in that cycle. The result and the new SP are valid while done is high, and SP changes only in the cycle done is high.
- R9: Stack pointer arithmetic wraps modulo 2^16 for decrements, for increments, and for the SP+1 address.
- R10: After reset, SP and the result are 0x0000 and busy, done and the memory request are low.
- R11: A start strobe that arrives while busy is ignored, and no memory request is raised while idle.
- R12: Codes 6 and 7 finish with a done pulse, make no memory access, and leave SP and the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| op_i | input | 3 | Operation code |
| operand_i | input | 16 | Register pair, return address, HL or new SP |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Value read by pop, return or exchange |
| sp_o | output | 16 | Stack pointer |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 16 | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_rdata_i | input | 8 | Read byte, valid the cycle after acceptance |

## Verification
The operations are run back-to-back against a memory model, so each result depends on bytes written by earlier operations. This exposes swapped byte halves, wrong offsets and a wrong access order. Each sequence is run both with ready always high and with ready alternating, which separates correct request holding and read-data timing from designs that only work without stalls. Pushes, pops and an exchange across the 0x0000/0xFFFF boundary check the wrap. Directed cases check the exact access trace of push, pop and exchange, the single-cycle latency of load-SP, and a start strobe that arrives mid-sequence.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam logic [2:0] OP_PUSH = 3'd0;
  localparam logic [2:0] OP_POP  = 3'd1;
  localparam logic [2:0] OP_CALL = 3'd2;
  localparam logic [2:0] OP_RET  = 3'd3;
  localparam logic [2:0] OP_XCHG = 3'd4;
  localparam logic [2:0] OP_LDSP = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } stk_state_e;

  function automatic logic is_store_op(input logic [2:0] op);
    return (op == OP_PUSH) || (op == OP_CALL);
  endfunction

  function automatic logic is_load_op(input logic [2:0] op);
    return (op == OP_POP) || (op == OP_RET);
  endfunction

  function automatic logic uses_mem(input logic [2:0] op);
    return is_store_op(op) || is_load_op(op) || (op == OP_XCHG);
  endfunction

endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/stk_addr_gen.sv
module stk_addr_gen
  import stk_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int PAIR_W = 2 * BYTE_W
) (
  input  logic [2:0]        op_i,
  input  logic [1:0]        step_i,
  input  logic [PAIR_W-1:0] base_i,
  input  logic [PAIR_W-1:0] operand_i,
  output logic [PAIR_W-1:0] addr_o,
  output logic              we_o,
  output logic              hi_o,
  output logic              last_o,
  output logic [BYTE_W-1:0] wdata_o
);

  // Per-step address, direction and byte lane for each sequence.
  always_comb begin
    addr_o = base_i;
    we_o   = 1'b0;
    hi_o   = 1'b0;
    last_o = 1'b0;
    if (is_store_op(op_i)) begin
      // step 0: SP-1 gets the upper byte; step 1: SP-2 gets the lower byte
      we_o   = 1'b1;
      hi_o   = ~step_i[0];
      addr_o = base_i - (step_i[0] ? PAIR_W'(2) : PAIR_W'(1));
      last_o = step_i[0];
    end else if (is_load_op(op_i)) begin
      // step 0: SP holds the lower byte; step 1: SP+1 holds the upper byte
      hi_o   = step_i[0];
      addr_o = base_i + PAIR_W'(step_i[0]);
      last_o = step_i[0];
    end else if (op_i == OP_XCHG) begin
      // steps 0,1 read SP, SP+1; steps 2,3 write SP, SP+1
      we_o   = step_i[1];
      hi_o   = step_i[0];
      addr_o = base_i + PAIR_W'(step_i[0]);
      last_o = &step_i;
    end
    wdata_o = hi_o ? operand_i[PAIR_W-1:BYTE_W] : operand_i[BYTE_W-1:0];
  end

endmodule

// File: rtl/stk_sp_reg.sv
module stk_sp_reg
  import stk_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int PAIR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [2:0]        op_i,
  input  logic [PAIR_W-1:0] operand_i,
  output logic [PAIR_W-1:0] sp_o
);

  logic [PAIR_W-1:0] sp_q;
  logic [PAIR_W-1:0] sp_d;

  always_comb begin
    if (is_store_op(op_i)) begin
      sp_d = sp_q - PAIR_W'(2);
    end else if (is_load_op(op_i)) begin
      sp_d = sp_q + PAIR_W'(2);
    end else if (op_i == OP_LDSP) begin
      sp_d = operand_i;
    end else begin
      sp_d = sp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (load_en) begin
      sp_q <= sp_d;
    end
  end

  assign sp_o = sp_q;

endmodule

// File: rtl/stk_rd_gather.sv
module stk_rd_gather #(
  parameter  int BYTE_W = 8,
  localparam int PAIR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              cap_hi,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [PAIR_W-1:0] result_o
);

  logic [BYTE_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (cap_en && !cap_hi) begin
      lo_q <= rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (cap_en && cap_hi) begin
      hi_q <= rdata_i;
    end
  end

  assign result_o = {hi_q, lo_q};

endmodule

// File: rtl/stk_xfer_seq.sv
module stk_xfer_seq
  import stk_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int PAIR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [PAIR_W-1:0] operand_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [PAIR_W-1:0] result_o,
  output logic [PAIR_W-1:0] sp_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PAIR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [BYTE_W-1:0] mem_rdata_i
);

  logic              rst_n_int;
  stk_state_e        state_q, state_d;
  logic [1:0]        step_q, step_d;
  logic [2:0]        op_q;
  logic [PAIR_W-1:0] opnd_q;
  logic              cmd_load;
  logic              sp_load;
  logic              rd_pend_q, rd_pend_d;
  logic              rd_hi_q, rd_hi_d;
  logic              acc_we, acc_hi, acc_last;
  logic              hs;
  logic [2:0]        sp_op;
  logic [PAIR_W-1:0] sp_opnd;

  stk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  stk_addr_gen #(.BYTE_W(BYTE_W)) u_addr (
    .op_i      (op_q),
    .step_i    (step_q),
    .base_i    (sp_o),
    .operand_i (opnd_q),
    .addr_o    (mem_addr_o),
    .we_o      (acc_we),
    .hi_o      (acc_hi),
    .last_o    (acc_last),
    .wdata_o   (mem_wdata_o)
  );

  // Load-SP and no-op codes finish straight from idle, so they use the live command.
  assign sp_op   = (state_q == ST_IDLE) ? op_i      : op_q;
  assign sp_opnd = (state_q == ST_IDLE) ? operand_i : opnd_q;

  stk_sp_reg #(.BYTE_W(BYTE_W)) u_sp (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_en   (sp_load),
    .op_i      (sp_op),
    .operand_i (sp_opnd),
    .sp_o      (sp_o)
  );

  stk_rd_gather #(.BYTE_W(BYTE_W)) u_gather (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .cap_en   (rd_pend_q),
    .cap_hi   (rd_hi_q),
    .rdata_i  (mem_rdata_i),
    .result_o (result_o)
  );

  assign mem_req_o = (state_q == ST_XFER);
  assign mem_we_o  = mem_req_o & acc_we;
  assign hs        = mem_req_o & mem_ready_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_FIN);
  assign rd_pend_d = hs & ~acc_we;
  assign rd_hi_d   = acc_hi;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    cmd_load = 1'b0;
    sp_load  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cmd_load = 1'b1;
          step_d   = 2'd0;
          if (uses_mem(op_i)) begin
            state_d = ST_XFER;
          end else begin
            state_d = ST_FIN;
            sp_load = 1'b1;
          end
        end
      end
      ST_XFER: begin
        if (mem_ready_i) begin
          if (acc_last) begin
            if (acc_we) begin
              state_d = ST_FIN;
              sp_load = 1'b1;
            end else begin
              state_d = ST_DRAIN;
            end
          end else begin
            step_d = step_q + 2'd1;
          end
        end
      end
      ST_DRAIN: begin
        state_d = ST_FIN;
        sp_load = 1'b1;
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q   <= ST_IDLE;
      step_q    <= 2'd0;
      rd_pend_q <= 1'b0;
      rd_hi_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      step_q    <= step_d;
      rd_pend_q <= rd_pend_d;
      rd_hi_q   <= rd_hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      op_q   <= '0;
      opnd_q <= '0;
    end else if (cmd_load) begin
      op_q   <= op_i;
      opnd_q <= operand_i;
    end
  end

endmodule

// File: rtl/stk_xfer_seq_chk.sv
module stk_xfer_seq_chk #(
  parameter  int BYTE_W = 8,
  localparam int PAIR_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [PAIR_W-1:0] sp_o,
  input logic              mem_req_o,
  input logic              mem_ready_i,
  input logic              mem_we_o,
  input logic [PAIR_W-1:0] mem_addr_o,
  input logic [BYTE_W-1:0] mem_wdata_o
);

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)))
    else $error("a_r6_req_hold");

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("a_r8_done_pulse");

  a_r8_sp_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_o) |-> done_o)
    else $error("a_r8_sp_moves_on_done");

  a_r8_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o)
    else $error("a_r8_done_no_req");

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o)
    else $error("a_r11_idle_quiet");

  a_r11_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i))
    else $error("a_r11_busy_from_start");

endmodule

bind stk_xfer_seq stk_xfer_seq_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .sp_o        (sp_o),
  .mem_req_o   (mem_req_o),
  .mem_ready_i (mem_ready_i),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/stk_xfer_seq_tb.sv
module stk_xfer_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op_r;
  logic [15:0] opnd_r;
  logic        busy, done;
  logic [15:0] result, sp;
  logic        req, we;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        ready;
  logic [7:0]  rdata;

  int applied = 0;
  int miscmp  = 0;

  logic [7:0]  mem [256];
  int          log_n;
  logic [15:0] log_addr [8];
  logic        log_we   [8];
  logic [7:0]  log_data [8];
  int          stall_mode;
  logic        pend_rd;
  logic [7:0]  pend_a;
  logic [15:0] res_seen, sp_seen;

  always #2 clk = ~clk;

  stk_xfer_seq u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .op_i        (op_r),
    .operand_i   (opnd_r),
    .busy_o      (busy),
    .done_o      (done),
    .result_o    (result),
    .sp_o        (sp),
    .mem_req_o   (req),
    .mem_we_o    (we),
    .mem_addr_o  (addr),
    .mem_wdata_o (wdata),
    .mem_ready_i (ready),
    .mem_rdata_i (rdata)
  );

  // Memory model: handshake decided at the falling edge for the next rising edge.
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    ready = 1'b1; rdata = 8'h00; pend_rd = 1'b0; pend_a = 8'h00;
    log_n = 0; stall_mode = 0;
  end

  always @(negedge clk) begin
    if (pend_rd) rdata = mem[pend_a];
    pend_rd = 1'b0;
    ready = (stall_mode == 0) ? 1'b1 : ~ready;
    if (req && ready) begin
      if (log_n < 8) begin
        log_addr[log_n] = addr; log_we[log_n] = we; log_data[log_n] = we ? wdata : 8'h00;
      end
      log_n++;
      if (we) mem[addr[7:0]] = wdata;
      else begin pend_rd = 1'b1; pend_a = addr[7:0]; end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [15:0] opnd, output int lat);
    @(negedge clk);
    log_n = 0; start = 1'b1; op_r = op; opnd_r = opnd;
    @(negedge clk);
    start = 1'b0; lat = 1;
    while (!done) begin @(negedge clk); lat++; end
    res_seen = result; sp_seen = sp;
    @(negedge clk);
    check("R8 done single pulse", {31'd0, done}, 32'd0);
  endtask

  function automatic int exp_count(input logic [2:0] op);
    if (op <= 3'd3) return 2;
    if (op == 3'd4) return 4;
    return 0;
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd2: return "R1 store";
      3'd1, 3'd3: return "R2 load";
      3'd4:       return "R4 exchange";
      3'd5:       return "R5 load-SP";
      default:    return "R12 unused code";
    endcase
  endfunction

  // {op, operand, stall, expected result, expected SP}; wrap cases (R9) at the end
  localparam int NV = 15;
  localparam logic [51:0] VEC [NV] = '{
    {3'd5, 16'h2010, 1'b0, 16'h0000, 16'h2010},
    {3'd0, 16'h1234, 1'b1, 16'h0000, 16'h200E},
    {3'd0, 16'hA5C3, 1'b0, 16'h0000, 16'h200C},
    {3'd1, 16'h0000, 1'b1, 16'hA5C3, 16'h200E},
    {3'd4, 16'h5566, 1'b1, 16'h1234, 16'h200E},
    {3'd1, 16'h0000, 1'b0, 16'h5566, 16'h2010},
    {3'd2, 16'h0ABC, 1'b0, 16'h5566, 16'h200E},
    {3'd3, 16'h0000, 1'b1, 16'h0ABC, 16'h2010},
    {3'd6, 16'hFFFF, 1'b0, 16'h0ABC, 16'h2010},
    {3'd5, 16'h0000, 1'b0, 16'h0ABC, 16'h0000},
    {3'd0, 16'hBEEF, 1'b1, 16'h0ABC, 16'hFFFE},
    {3'd1, 16'h0000, 1'b0, 16'hBEEF, 16'h0000},
    {3'd5, 16'hFFFF, 1'b0, 16'hBEEF, 16'hFFFF},
    {3'd4, 16'h7788, 1'b1, 16'h00BE, 16'hFFFF},
    {3'd1, 16'h0000, 1'b0, 16'h7788, 16'h0001}
  };

  initial begin
    repeat (100000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

  initial begin
    int lat;
    rst_n = 1'b0; start = 1'b0; op_r = 3'd0; opnd_r = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 sp", {16'd0, sp}, 32'h0);
    check("R10 result", {16'd0, result}, 32'h0);
    check("R10 busy/done/req", {29'd0, busy, done, req}, 32'h0);

    // Table walk; R6 and R7 exercised by the stalled entries
    for (int v = 0; v < NV; v++) begin
      logic [2:0]  vop;
      logic [15:0] vopnd, vres, vsp;
      {vop, vopnd, stall_mode[0], vres, vsp} = VEC[v];
      stall_mode[31:1] = '0;
      run_op(vop, vopnd, lat);
      check($sformatf("%s vec%0d result (R6 R7 R9)", tag_of(vop), v), {16'd0, res_seen}, {16'd0, vres});
      check($sformatf("%s vec%0d sp", tag_of(vop), v), {16'd0, sp_seen}, {16'd0, vsp});
      check($sformatf("%s vec%0d access count", tag_of(vop), v), log_n, exp_count(vop));
    end
    stall_mode = 0;

    // R1 / R3: store trace, accumulator at the higher address
    run_op(3'd5, 16'h3000, lat);
    run_op(3'd0, 16'hA5C3, lat);
    check("R1 R3 first write", {log_we[0], log_addr[0], log_data[0]}, {1'b1, 16'h2FFF, 8'hA5});
    check("R1 R3 second write", {log_we[1], log_addr[1], log_data[1]}, {1'b1, 16'h2FFE, 8'hC3});
    // R2 / R3: load trace and reassembly
    run_op(3'd1, 16'h0000, lat);
    check("R2 first read", {log_we[0], log_addr[0]}, {1'b0, 16'h2FFE});
    check("R2 second read", {log_we[1], log_addr[1]}, {1'b0, 16'h2FFF});
    check("R3 acc/flags restored", {16'd0, res_seen}, 32'h0000A5C3);
    // R4: exchange trace at SP 0x3000 (bytes 0x77 at 0x3000, 0x00 at 0x3001)
    run_op(3'd4, 16'h1357, lat);
    check("R4 step0", {log_we[0], log_addr[0]}, {1'b0, 16'h3000});
    check("R4 step1", {log_we[1], log_addr[1]}, {1'b0, 16'h3001});
    check("R4 step2", {log_we[2], log_addr[2], log_data[2]}, {1'b1, 16'h3000, 8'h57});
    check("R4 step3", {log_we[3], log_addr[3], log_data[3]}, {1'b1, 16'h3001, 8'h13});
    check("R4 old top", {16'd0, res_seen}, 32'h00000077);
    check("R4 sp kept", {16'd0, sp_seen}, 32'h00003000);
    // R5: latency of one cycle, no access
    run_op(3'd5, 16'h4000, lat);
    check("R5 latency", lat, 1);
    check("R5 no access", log_n, 0);
    check("R5 sp", {16'd0, sp_seen}, 32'h00004000);

    // R11: second start during a stalled store is ignored
    stall_mode = 1;
    @(negedge clk); log_n = 0; start = 1'b1; op_r = 3'd0; opnd_r = 16'h0102;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1; op_r = 3'd5; opnd_r = 16'h1111;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    check("R11 sp after ignored start", {16'd0, sp}, 32'h00003FFE);
    repeat (4) @(negedge clk);
    check("R11 idle afterwards", {31'd0, busy}, 32'h0);
    check("R11 sp unchanged", {16'd0, sp}, 32'h00003FFE);
    check("R11 access count", log_n, 2);
    stall_mode = 0;

    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  end

endmodule